// File: doc/BRIEF.md
# Multi-Lane Transmit Phase Compensation FIFO

This block carries parallel transmit words for several lanes from one fabric-side write clock into the parallel clock of each transmitter lane. Every lane holds an eight-entry asynchronous FIFO. Its pointers are Gray-coded and cross between the two clock domains through two-flop synchronizers. After reset a lane starts reading only once it sees at least two words waiting. This gives every lane a fixed starting margin against clock phase drift.

A static two-bit mode input is sampled while the write reset is asserted. Three behaviours are available:

- **Independent:** each lane runs its own pointer pair and control logic on its own read clock.
- **Bonded:** the pointer pair and control logic of lane 0 serve every lane, and all lanes read on the lane 0 read clock. Every lane therefore shows the same FIFO latency.
- **Registered:** the FIFO storage is bypassed and each lane passes through a single register stage on its read clock.

The write side is a per-lane valid/ready stream. A word transfers on a write clock edge where both valid and ready are high. Ready falls only when the lane's FIFO is full. A source that keeps valid high while ready is low has its word dropped, and the lane records an overflow. The read side has no back-pressure: the serializer takes one word per read clock whenever the read valid bit is high. A read slot that finds the FIFO empty after the lane has started records an underflow. Both error bits are sticky until reset.

Top module: `txpc_fifo`

## Requirements
- R1: With both resets asserted, and after their release before any write, every rd_valid bit, ovf bit and udf bit is 0, and every wr_ready bit is 1 in the two FIFO modes.
- R2: In the FIFO modes each lane delivers every accepted word exactly once, in acceptance order, with no duplicate or invented word.
- R3: A lane begins reading only after its synchronized fill reaches 2 entries. A single written word is never read out, and no underflow is recorded before reading has begun.
- R4: wr_ready of a lane is low exactly while that lane holds 8 unread entries. With the lane's read clock stopped, exactly 8 words are accepted.
- R5: A write attempt (wr_valid high) while wr_ready is low sets that lane's ovf bit, which stays set until reset. Lanes with no such attempt keep ovf at 0.
- R6: Once a lane has started reading, a read slot with no entry available sets its udf bit, which stays set until reset.
- R7: In independent mode (mode 0, and the reserved value 3) each lane uses its own pointers and its own rd_clk bit. Stopping one lane's read clock does not change the flow, ready or flags of any other lane.
- R8: In bonded mode (mode 1), wr_valid of lane 0 writes all lanes and the wr_valid bits of the other lanes are ignored. Every lane's wr_ready, ovf and udf copies those of lane 0.
- R9: In bonded mode all lanes are read on rd_clk bit 0, and rd_valid is equal across all lanes on every read cycle.
- R10: In registered mode (mode 2), rd_data and rd_valid of each lane equal that lane's wr_data and wr_valid captured on the previous edge of its rd_clk bit, which is one cycle of latency. wr_ready stays all ones and no flag is set.
- R11: The mode is captured only on write clock edges while wr_rst_n is low. A change of mode_i after reset release has no effect until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Fabric-side write clock |
| wr_rst_n | input | 1 | Write-domain reset, active low; mode is captured while low |
| rd_clk | input | LANES | Per-lane transmitter parallel clock; bit 0 drives all lanes in bonded mode |
| rd_rst_n | input | 1 | Read-domain reset, active low, asynchronous assert |
| mode_i | input | 2 | 0 independent, 1 bonded, 2 registered, 3 treated as independent |
| wr_valid | input | LANES | Per-lane write word valid |
| wr_ready | output | LANES | Per-lane write ready, low when the lane FIFO is full |
| wr_data | input | LANES*DW | Per-lane write words, lane i at bits i*DW upward |
| rd_valid | output | LANES | Per-lane read word valid |
| rd_data | output | LANES*DW | Per-lane read words, lane i at bits i*DW upward |
| ovf | output | LANES | Sticky overflow per lane |
| udf | output | LANES | Sticky underflow per lane |

## Verification
The FIFO modes are driven with three write patterns:

- **Steady stream on every lane:** shows in-order, lossless transfer.
- **Staggered gaps that differ per lane:** exposes any mixing of lane counters and drains the FIFOs into underflow.
- **A single word followed by a second:** separates the start threshold from a plain not-empty test.

A run with one lane's read clock stopped tells independent pointer sets apart from shared ones, because only that lane fills, back-pressures and overflows. In bonded mode, valid is driven on lane 0 only, with gaps, and mode_i is changed after reset. Output on the other lanes, with identical valid timing, proves the shared control and that the mode was latched. In registered mode an irregular valid pattern is checked cycle by cycle, which pins the latency at exactly one stage.

// File: rtl/txpc_pkg.sv
package txpc_pkg;

  typedef enum logic [1:0] {
    TXPC_INDEP = 2'd0,
    TXPC_BOND  = 2'd1,
    TXPC_REG   = 2'd2,
    TXPC_RSVD  = 2'd3
  } txpc_mode_e;

endpackage

// File: rtl/txpc_sync.sv
module txpc_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage1, stage2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= d_i;
      stage2 <= stage1;
    end
  end

  assign q_o = stage2;
endmodule

// File: rtl/txpc_wr_ctrl.sv
module txpc_wr_ctrl #(
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active_i,
  input  logic          valid_i,
  input  logic [PW-1:0] rgray_i,
  output logic          ready_o,
  output logic          wen_o,
  output logic [AW-1:0] waddr_o,
  output logic [PW-1:0] wgray_o,
  output logic          ovf_o
);
  logic [PW-1:0] rgray_s, rbin_s, wbin, wbin_nxt, fill;
  logic          full;

  function automatic logic [PW-1:0] gray_to_bin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int k = PW - 2; k >= 0; k--) b[k] = b[k+1] ^ g[k];
    return b;
  endfunction

  txpc_sync #(.W(PW)) u_rsync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (rgray_i),
    .q_o   (rgray_s)
  );

  assign rbin_s   = gray_to_bin(rgray_s);
  assign fill     = wbin - rbin_s;
  assign full     = (fill == PW'(DEPTH));
  assign ready_o  = !full;
  assign wen_o    = active_i && valid_i && !full;
  assign wbin_nxt = wbin + PW'(wen_o);
  assign waddr_o  = wbin[AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin    <= '0;
      wgray_o <= '0;
      ovf_o   <= 1'b0;
    end else begin
      wbin    <= wbin_nxt;
      wgray_o <= wbin_nxt ^ (wbin_nxt >> 1);
      if (active_i && valid_i && full) ovf_o <= 1'b1;
    end
  end
endmodule

// File: rtl/txpc_rd_ctrl.sv
module txpc_rd_ctrl #(
  parameter int DEPTH      = 8,
  parameter int START_FILL = 2,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active_i,
  input  logic [PW-1:0] wgray_i,
  output logic          ren_o,
  output logic [AW-1:0] raddr_o,
  output logic [PW-1:0] rgray_o,
  output logic          udf_o
);
  logic [PW-1:0] wgray_s, wbin_s, rbin, rbin_nxt, fill;
  logic          started;

  function automatic logic [PW-1:0] gray_to_bin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int k = PW - 2; k >= 0; k--) b[k] = b[k+1] ^ g[k];
    return b;
  endfunction

  txpc_sync #(.W(PW)) u_wsync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (wgray_i),
    .q_o   (wgray_s)
  );

  assign wbin_s   = gray_to_bin(wgray_s);
  assign fill     = wbin_s - rbin;
  assign ren_o    = active_i && started && (fill != '0);
  assign rbin_nxt = rbin + PW'(ren_o);
  assign raddr_o  = rbin[AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin    <= '0;
      rgray_o <= '0;
      started <= 1'b0;
      udf_o   <= 1'b0;
    end else begin
      rbin    <= rbin_nxt;
      rgray_o <= rbin_nxt ^ (rbin_nxt >> 1);
      if (active_i) begin
        if (!started) begin
          if (fill >= PW'(START_FILL)) started <= 1'b1;
        end else if (fill == '0) begin
          udf_o <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/txpc_lane.sv
module txpc_lane #(
  parameter int DW    = 8,
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          wr_clk,
  input  logic          rd_clk,
  input  logic          rd_rst_n,
  input  logic          wen_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          ren_i,
  input  logic [AW-1:0] raddr_i,
  input  logic          bypass_i,
  input  logic          byp_valid_i,
  output logic [DW-1:0] rd_data_o,
  output logic          rd_valid_o
);
  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge wr_clk) begin
    if (wen_i) store[waddr_i] <= wdata_i;
  end

  always_ff @(posedge rd_clk or negedge rd_rst_n) begin
    if (!rd_rst_n) begin
      rd_data_o  <= '0;
      rd_valid_o <= 1'b0;
    end else if (bypass_i) begin
      rd_data_o  <= wdata_i;
      rd_valid_o <= byp_valid_i;
    end else begin
      if (ren_i) rd_data_o <= store[raddr_i];
      rd_valid_o <= ren_i;
    end
  end
endmodule

// File: rtl/txpc_fifo.sv
module txpc_fifo #(
  parameter int LANES      = 4,
  parameter int DW         = 8,
  parameter int DEPTH      = 8,
  parameter int START_FILL = 2
) (
  input  logic                wr_clk,
  input  logic                wr_rst_n,
  input  logic [LANES-1:0]    rd_clk,
  input  logic                rd_rst_n,
  input  logic [1:0]          mode_i,
  input  logic [LANES-1:0]    wr_valid,
  output logic [LANES-1:0]    wr_ready,
  input  logic [LANES*DW-1:0] wr_data,
  output logic [LANES-1:0]    rd_valid,
  output logic [LANES*DW-1:0] rd_data,
  output logic [LANES-1:0]    ovf,
  output logic [LANES-1:0]    udf
);
  import txpc_pkg::*;

  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  txpc_mode_e mode_q;
  logic       is_bond, is_reg;

  always_ff @(posedge wr_clk) begin
    if (!wr_rst_n) mode_q <= txpc_mode_e'(mode_i);
  end

  assign is_bond = (mode_q == TXPC_BOND);
  assign is_reg  = (mode_q == TXPC_REG);

  logic [LANES-1:0] lane_clk;
  logic [LANES-1:0] c_rdy, c_wen, c_ren, c_ovf, c_udf;
  logic [AW-1:0]    c_waddr [LANES];
  logic [AW-1:0]    c_raddr [LANES];
  logic [PW-1:0]    c_wgray [LANES];
  logic [PW-1:0]    c_rgray [LANES];

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam bit LEAD = (i == 0);
    logic act;

    assign act         = !is_reg && (LEAD || !is_bond);
    assign lane_clk[i] = is_bond ? rd_clk[0] : rd_clk[i];

    txpc_wr_ctrl #(.DEPTH(DEPTH)) u_wctl (
      .clk      (wr_clk),
      .rst_n    (wr_rst_n),
      .active_i (act),
      .valid_i  (wr_valid[i]),
      .rgray_i  (c_rgray[i]),
      .ready_o  (c_rdy[i]),
      .wen_o    (c_wen[i]),
      .waddr_o  (c_waddr[i]),
      .wgray_o  (c_wgray[i]),
      .ovf_o    (c_ovf[i])
    );

    txpc_rd_ctrl #(.DEPTH(DEPTH), .START_FILL(START_FILL)) u_rctl (
      .clk      (lane_clk[i]),
      .rst_n    (rd_rst_n),
      .active_i (act),
      .wgray_i  (c_wgray[i]),
      .ren_o    (c_ren[i]),
      .raddr_o  (c_raddr[i]),
      .rgray_o  (c_rgray[i]),
      .udf_o    (c_udf[i])
    );

    txpc_lane #(.DW(DW), .DEPTH(DEPTH)) u_lane (
      .wr_clk      (wr_clk),
      .rd_clk      (lane_clk[i]),
      .rd_rst_n    (rd_rst_n),
      .wen_i       (is_bond ? c_wen[0]   : c_wen[i]),
      .waddr_i     (is_bond ? c_waddr[0] : c_waddr[i]),
      .wdata_i     (wr_data[i*DW +: DW]),
      .ren_i       (is_bond ? c_ren[0]   : c_ren[i]),
      .raddr_i     (is_bond ? c_raddr[0] : c_raddr[i]),
      .bypass_i    (is_reg),
      .byp_valid_i (wr_valid[i]),
      .rd_data_o   (rd_data[i*DW +: DW]),
      .rd_valid_o  (rd_valid[i])
    );

    assign wr_ready[i] = is_reg ? 1'b1 : (is_bond ? c_rdy[0] : c_rdy[i]);
    assign ovf[i]      = is_bond ? c_ovf[0] : c_ovf[i];
    assign udf[i]      = is_bond ? c_udf[0] : c_udf[i];
  end
endmodule

// File: rtl/txpc_fifo_chk.sv
module txpc_fifo_chk #(
  parameter int LANES = 4,
  parameter int DW    = 8
) (
  input logic                wr_clk,
  input logic                wr_rst_n,
  input logic [LANES-1:0]    rd_clk,
  input logic                rd_rst_n,
  input txpc_pkg::txpc_mode_e mode_q,
  input logic [LANES-1:0]    wr_valid,
  input logic [LANES-1:0]    wr_ready,
  input logic [LANES*DW-1:0] wr_data,
  input logic [LANES-1:0]    rd_valid,
  input logic [LANES*DW-1:0] rd_data,
  input logic [LANES-1:0]    ovf,
  input logic [LANES-1:0]    udf
);
  import txpc_pkg::*;

  a_r9_bond_valid_equal: assert property (@(posedge rd_clk[0]) disable iff (!rd_rst_n)
    (mode_q == TXPC_BOND) |-> (rd_valid == '0 || rd_valid == '1));

  a_r8_bond_ready_equal: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    (mode_q == TXPC_BOND) |-> (wr_ready == '0 || wr_ready == '1));

  a_r10_reg_ready: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    (mode_q == TXPC_REG) |-> (wr_ready == '1 && ovf == '0));

  a_r10_reg_one_stage: assert property (@(posedge rd_clk[0]) disable iff (!rd_rst_n || !wr_rst_n)
    (mode_q == TXPC_REG) |=> (rd_valid[0] == $past(wr_valid[0]) &&
                              rd_data[DW-1:0] == $past(wr_data[DW-1:0])));

  a_r5_ovf_sticky: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    (ovf != '0) |=> ((ovf & $past(ovf)) == $past(ovf)));

  a_r5_ovf_cause: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    $rose(ovf[0]) |-> $past(wr_valid[0] && !wr_ready[0]));

  a_r6_udf_sticky: assert property (@(posedge rd_clk[0]) disable iff (!rd_rst_n)
    udf[0] |=> udf[0]);
endmodule

bind txpc_fifo txpc_fifo_chk #(.LANES(LANES), .DW(DW)) u_txpc_chk (
  .wr_clk   (wr_clk),
  .wr_rst_n (wr_rst_n),
  .rd_clk   (rd_clk),
  .rd_rst_n (rd_rst_n),
  .mode_q   (mode_q),
  .wr_valid (wr_valid),
  .wr_ready (wr_ready),
  .wr_data  (wr_data),
  .rd_valid (rd_valid),
  .rd_data  (rd_data),
  .ovf      (ovf),
  .udf      (udf)
);

// File: tb/test_txpc_fifo.sv
module test_txpc_fifo;
  localparam int CLK_PERIOD = 10;
  localparam int L  = 4;
  localparam int DW = 8;

  logic            wr_clk = 1'b0;
  logic            wr_rst_n, rd_rst_n;
  logic [L-1:0]    rd_clk;
  logic [1:0]      mode_i;
  logic [L-1:0]    wr_valid, wr_ready, rd_valid, ovf, udf;
  logic [L*DW-1:0] wr_data, rd_data;
  logic            lane1_run = 1'b1;

  int checks = 0, errors = 0;
  int cnt [L];
  logic [L-1:0] pv, pr;
  int got [L][64];
  int ngot [L];
  bit mon_bond = 1'b0;
  int bond_bad = 0;

  txpc_fifo i_txpc_fifo (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .rd_clk(rd_clk), .rd_rst_n(rd_rst_n),
    .mode_i(mode_i), .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_data(rd_data), .ovf(ovf), .udf(udf)
  );

  always #(CLK_PERIOD/2) wr_clk = ~wr_clk;

  for (genvar g = 0; g < L; g++) begin : g_rck
    logic c = 1'b0;
    initial begin
      #(g);
      forever begin
        #(CLK_PERIOD/2);
        c = (g == 1 && !lane1_run) ? 1'b0 : ~c;
      end
    end
    assign rd_clk[g] = c;
  end

  always @(posedge wr_clk) begin
    #8;
    for (int i = 0; i < L; i++)
      if (rd_valid[i] && ngot[i] < 64) begin
        got[i][ngot[i]] = int'(rd_data[i*DW +: DW]);
        ngot[i]++;
      end
    if (mon_bond && !(rd_valid == '0 || rd_valid == '1)) bond_bad++;
  end

  function automatic int beat(int lane, int k);
    return ((lane & 3) << 6) | (k & 63);
  endfunction

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clear_streams();
    for (int i = 0; i < L; i++) ngot[i] = 0;
  endtask

  task automatic do_reset(input logic [1:0] m);
    wr_rst_n = 1'b0; rd_rst_n = 1'b0; mode_i = m;
    wr_valid = '0; wr_data = '0; pv = '0; pr = '0;
    for (int i = 0; i < L; i++) cnt[i] = 0;
    repeat (3) @(posedge wr_clk);
    @(negedge wr_clk);
    wr_rst_n = 1'b1; rd_rst_n = 1'b1;
    clear_streams();
  endtask

  task automatic drive_step(input logic [L-1:0] vmask, input bit bonded);
    @(negedge wr_clk);
    if (bonded) begin
      if (pv[0] && pr[0]) for (int i = 0; i < L; i++) cnt[i]++;
    end else begin
      for (int i = 0; i < L; i++) if (pv[i] && pr[i]) cnt[i]++;
    end
    wr_valid = vmask;
    for (int i = 0; i < L; i++) wr_data[i*DW +: DW] = DW'(beat(i, cnt[i]));
    pv = vmask;
    pr = wr_ready;
  endtask

  task automatic idle(input int n, input bit bonded);
    for (int k = 0; k < n; k++) drive_step('0, bonded);
  endtask

  task automatic check_stream(input int lane, input int n, input string req);
    int bad = -1;
    check(ngot[lane] == n, req, $sformatf("lane %0d word count", lane), ngot[lane], n);
    for (int k = 0; k < n && k < ngot[lane]; k++)
      if (bad < 0 && got[lane][k] != beat(lane, k)) bad = k;
    check(bad < 0, req, $sformatf("lane %0d word order (first bad index %0d)", lane, bad),
          bad < 0 ? 0 : got[lane][bad], bad < 0 ? 0 : beat(lane, bad));
  endtask

  task automatic t_reset();
    do_reset(2'd0);
    @(posedge wr_clk); #8;
    check(rd_valid == '0, "R1", "rd_valid after reset", int'(rd_valid), 0);
    check(ovf == '0 && udf == '0, "R1", "flags after reset", int'({ovf, udf}), 0);
    check(wr_ready == '1, "R1", "wr_ready after reset", int'(wr_ready), 15);
  endtask

  task automatic t_indep_stream();
    do_reset(2'd0);
    for (int k = 0; k < 20; k++) drive_step('1, 1'b0);
    for (int k = 0; k < 15; k++) begin
      logic [L-1:0] v;
      for (int i = 0; i < L; i++) v[i] = ((k + i) % 3) != 0;
      drive_step(v, 1'b0);
    end
    idle(30, 1'b0);
    for (int i = 0; i < L; i++) check_stream(i, cnt[i], "R2");
    check(udf == '1, "R6", "udf after drain", int'(udf), 15);
    check(ovf == '0, "R5", "no overflow on balanced flow", int'(ovf), 0);
  endtask

  task automatic t_start();
    do_reset(2'd0);
    drive_step('1, 1'b0);
    idle(20, 1'b0);
    check(ngot[0] + ngot[1] + ngot[2] + ngot[3] == 0, "R3", "words read with fill 1",
          ngot[0] + ngot[1] + ngot[2] + ngot[3], 0);
    check(udf == '0, "R3", "udf before start", int'(udf), 0);
    drive_step('1, 1'b0);
    idle(20, 1'b0);
    for (int i = 0; i < L; i++) check_stream(i, 2, "R3");
  endtask

  task automatic t_overflow();
    lane1_run = 1'b0;
    do_reset(2'd0);
    for (int k = 0; k < 12; k++) drive_step('1, 1'b0);
    idle(1, 1'b0);
    check(cnt[1] == 8, "R4", "words accepted with read clock stopped", cnt[1], 8);
    check(wr_ready[1] == 1'b0, "R4", "wr_ready of full lane", int'(wr_ready[1]), 0);
    check(cnt[0] == 12, "R7", "running lane accepted all", cnt[0], 12);
    check(ovf[1] == 1'b1, "R5", "ovf on full lane", int'(ovf[1]), 1);
    check(ovf[0] == 1'b0 && ovf[2] == 1'b0, "R5", "ovf on other lanes", int'(ovf), 2);
    lane1_run = 1'b1;
    idle(30, 1'b0);
    check_stream(1, 8, "R7");
    check_stream(0, 12, "R7");
    check(wr_ready[1] == 1'b1, "R4", "wr_ready after drain", int'(wr_ready[1]), 1);
    check(ovf[1] == 1'b1, "R5", "ovf sticky", int'(ovf[1]), 1);
  endtask

  task automatic t_bond();
    do_reset(2'd1);
    mode_i = 2'd2;
    bond_bad = 0;
    mon_bond = 1'b1;
    for (int k = 0; k < 16; k++) drive_step((k % 4 != 3) ? 4'b0001 : 4'b0000, 1'b1);
    idle(30, 1'b1);
    mon_bond = 1'b0;
    for (int i = 0; i < L; i++) check_stream(i, cnt[0], "R8");
    check(bond_bad == 0, "R9", "cycles with unequal rd_valid", bond_bad, 0);
    check(ngot[1] == 12, "R11", "lane 1 still bonded after mode change", ngot[1], 12);
    check(udf == '1, "R8", "udf mirrored across lanes", int'(udf), 15);
    check(wr_ready == '1 && ovf == '0, "R8", "ready and ovf mirrored", int'({wr_ready, ovf}), 240);
  endtask

  task automatic t_reg();
    int bad = 0;
    do_reset(2'd2);
    for (int k = 0; k < 12; k++) begin
      logic v;
      v = (k % 3) != 0;
      @(negedge wr_clk);
      wr_valid = {L{v}};
      for (int i = 0; i < L; i++) wr_data[i*DW +: DW] = DW'(beat(i, k));
      @(posedge wr_clk); #8;
      for (int i = 0; i < L; i++)
        if (rd_valid[i] != v || int'(rd_data[i*DW +: DW]) != beat(i, k)) bad++;
    end
    check(bad == 0, "R10", "one-stage mismatches", bad, 0);
    check(wr_ready == '1, "R10", "wr_ready in registered mode", int'(wr_ready), 15);
    check(ovf == '0 && udf == '0, "R10", "flags in registered mode", int'({ovf, udf}), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < L; i++) ngot[i] = 0;
    t_reset();
    t_indep_stream();
    t_start();
    t_overflow();
    t_bond();
    t_reg();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule